// File: doc/BRIEF.md
# Comparator Event Interrupt Detector

This block is the digital side of one analog voltage comparator. Software programs it through one 8-bit control and status register on a small single-cycle bus. The register chooses which analog input feeds the comparator's positive side, whether the analog inputs are attached, whether the comparator result is used at all, and which of eight trigger conditions raises an interrupt. The raw one-bit comparator result arrives from the analog model. A periodic sample tick arrives from an external timer and paces the debounced modes.

When the comparator is enabled, its result passes through as the gated output. When the trigger condition is met, a sticky flag is set. The flag stays set until software writes a zero to it, and it is combined with an external interrupt enable to form the request. Software may change the channel only while the inputs are detached. A write that tries to change the channel while they are attached keeps the old channel and raises a sticky misuse error.

The debounce filter is a four-state machine. Its states are DB_LO (stable low), DB_PEND_HI (one tick seen high), DB_HI (stable high) and DB_PEND_LO (one tick seen low). It changes state only on a sample tick. The transitions are:
- DB_LO goes to DB_PEND_HI on a high sample.
- DB_PEND_HI goes to DB_HI on a second high sample, or back to DB_LO on a low sample.
- DB_HI goes to DB_PEND_LO on a low sample.
- DB_PEND_LO goes to DB_LO on a second low sample, or back to DB_HI on a high sample.

While the comparator is disabled the filter is held in DB_LO. On the first enabled cycle it is loaded with DB_HI or DB_LO according to the raw input.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: After reset the register reads 8'hC0. That is channel 3, inputs detached, comparator disabled, flag clear and mode 0. The misuse error and the request are low.
- R2: When the bus address equals the register address, the read data shows the fields as follows: bits 7:6 are the channel, bit 5 is connect, bit 4 is the flag, bit 3 is enable and bits 2:0 are the mode. Any other address reads 0.
- R3: The gated output equals the raw comparator result while enable (bit 3) is 1, and is 0 while enable is 0.
- R4: While enable is 0, the flag cannot become set.
- R5: The flag stays set until a register write carries 0 in bit 4, which clears it. Writing 1 to bit 4 never sets it. A set condition in the same cycle as a clear wins.
- R6: In mode 3'b111 (high level) and mode 3'b000 (low level) the flag is set on every clock while the gated output is 1 (or 0, respectively). A clear during that time is therefore overridden.
- R7: The non-debounced edge modes act on every clock and set the flag one clock after the gated output changes. Mode 3'b001 responds to a rising change, 3'b100 to a falling change and 3'b101 to either change.
- R8: The debounced modes are 3'b011 (rising), 3'b110 (falling) and 3'b010 (either). In these modes a change is accepted only after the raw input has shown the new value on two consecutive sample ticks, and no change is accepted without ticks. A glitch that lasts for only one tick is ignored. The flag is set one clock after acceptance.
- R9: On the first clock with enable at 1, no event is detected. The edge and filter history is loaded from the current input, so enabling with the input already high causes no rising event.
- R10: A write that changes the channel while connect is 1 keeps the old channel, and this holds even if the same write clears connect. Such a write raises the misuse error, which stays set until reset. The other fields of that write still take effect. With connect at 0, the channel is written normally.
- R11: The connect output follows register bit 5.
- R12: The interrupt request is the flag ANDed with the interrupt-enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| cmp_raw | input | 1 | Raw comparator result |
| sample_tick | input | 1 | Debounce sample pulse from the timer |
| irq_en | input | 1 | External interrupt enable |
| chan_sel | output | 2 | Positive-input channel select |
| inputs_connect | output | 1 | Attaches the analog inputs |
| cmp_gated | output | 1 | Comparator result gated by enable |
| irq | output | 1 | Interrupt request |
| misuse_err | output | 1 | Sticky channel-change misuse error |

## Verification
Several properties are checked on every cycle:
- the gated output is forced low while the comparator is disabled;
- the flag never sets while disabled;
- the flag holds unless cleared by a write;
- the flag is untouched on the first enabled cycle;
- the filter's accepted value is frozen between ticks;
- the channel cannot move while the inputs are connected;
- the misuse error is sticky.

The bench scenarios show what those properties cannot: that each of the eight mode codes maps to its intended condition and reacts on the intended clock. They also cover two cases that need a specific stimulus pattern. One is the two-tick acceptance, including a one-tick glitch that is rejected. The other is a level mode overriding a software clear.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

    localparam int REG_W  = 8;
    localparam int CHAN_W = 2;

    typedef enum logic [2:0] {
        TM_LEVEL_LO = 3'b000,
        TM_RISE     = 3'b001,
        TM_TOG_DB   = 3'b010,
        TM_RISE_DB  = 3'b011,
        TM_FALL     = 3'b100,
        TM_TOG      = 3'b101,
        TM_FALL_DB  = 3'b110,
        TM_LEVEL_HI = 3'b111
    } trig_mode_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              conn;
        logic              flag;
        logic              en;
        trig_mode_e        mode;
    } ctl_t;

    localparam logic [REG_W-1:0] CTL_RESET = 8'hC0;

endpackage

// File: rtl/cmp_evt_debounce.sv
module cmp_evt_debounce (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic load,
    input  logic raw,
    input  logic tick,
    output logic acc
);

    typedef enum logic [1:0] {
        DB_LO      = 2'd0,
        DB_PEND_HI = 2'd1,
        DB_HI      = 2'd2,
        DB_PEND_LO = 2'd3
    } db_state_e;

    db_state_e state_q;
    db_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DB_LO: begin
                if (tick && raw) begin
                    state_d = DB_PEND_HI;
                end
            end
            DB_PEND_HI: begin
                if (tick) begin
                    state_d = raw ? DB_HI : DB_LO;
                end
            end
            DB_HI: begin
                if (tick && !raw) begin
                    state_d = DB_PEND_LO;
                end
            end
            DB_PEND_LO: begin
                if (tick) begin
                    state_d = raw ? DB_HI : DB_LO;
                end
            end
            default: state_d = DB_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_LO;
        end else if (!en) begin
            state_q <= DB_LO;
        end else if (load) begin
            state_q <= raw ? DB_HI : DB_LO;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        acc = (state_q == DB_HI) || (state_q == DB_PEND_LO);
    end

endmodule

// File: rtl/cmp_evt_detect.sv
module cmp_evt_detect
    import cmp_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  trig_mode_e mode,
    input  logic       raw,
    input  logic       tick,
    output logic       gated,
    output logic       rise,
    output logic       acc,
    output logic       set_flag
);

    logic en_prev_q;
    logic g_prev_q;
    logic a_prev_q;
    logic hit;

    always_comb begin
        gated = raw & en;
        rise  = en & ~en_prev_q;
    end

    cmp_evt_debounce u_db (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .load (rise),
        .raw  (gated),
        .tick (tick),
        .acc  (acc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_prev_q <= 1'b0;
            g_prev_q  <= 1'b0;
            a_prev_q  <= 1'b0;
        end else begin
            en_prev_q <= en;
            g_prev_q  <= gated;
            a_prev_q  <= rise ? gated : acc;
        end
    end

    always_comb begin
        hit = 1'b0;
        unique case (mode)
            TM_LEVEL_LO: hit = ~gated;
            TM_LEVEL_HI: hit = gated;
            TM_RISE:     hit = gated & ~g_prev_q;
            TM_FALL:     hit = ~gated & g_prev_q;
            TM_TOG:      hit = gated ^ g_prev_q;
            TM_RISE_DB:  hit = acc & ~a_prev_q;
            TM_FALL_DB:  hit = ~acc & a_prev_q;
            TM_TOG_DB:   hit = acc ^ a_prev_q;
            default:     hit = 1'b0;
        endcase
        set_flag = en & ~rise & hit;
    end

endmodule

// File: rtl/cmp_evt_regs.sv
module cmp_evt_regs
    import cmp_evt_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              set_flag,
    output ctl_t              ctl,
    output logic [REG_W-1:0]  rdata,
    output logic              wr_hit,
    output logic              misuse_err
);

    ctl_t ctl_q;
    ctl_t ctl_d;
    ctl_t wr_val;
    logic err_q;
    logic misuse;
    logic addr_hit;

    always_comb begin
        addr_hit = (addr == REG_ADDR);
        wr_hit   = we & addr_hit;
        wr_val   = ctl_t'(wdata);
        misuse   = wr_hit & ctl_q.conn & (wr_val.chan != ctl_q.chan);
        ctl_d    = ctl_q;
        if (wr_hit) begin
            ctl_d.chan = misuse ? ctl_q.chan : wr_val.chan;
            ctl_d.conn = wr_val.conn;
            ctl_d.en   = wr_val.en;
            ctl_d.mode = wr_val.mode;
            ctl_d.flag = wr_val.flag & ctl_q.flag;
        end
        if (set_flag) begin
            ctl_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= ctl_t'(CTL_RESET);
            err_q <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
            err_q <= err_q | misuse;
        end
    end

    always_comb begin
        ctl        = ctl_q;
        misuse_err = err_q;
        rdata      = addr_hit ? REG_W'(ctl_q) : '0;
    end

endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
    import cmp_evt_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              cmp_raw,
    input  logic              sample_tick,
    input  logic              irq_en,
    output logic [1:0]        chan_sel,
    output logic              inputs_connect,
    output logic              cmp_gated,
    output logic              irq,
    output logic              misuse_err
);

    ctl_t ctl;
    logic set_flag;
    logic wr_hit;
    logic en_rise;
    logic db_acc;
    logic ctl_en;
    logic ctl_flag;

    cmp_evt_regs #(
        .ADDR_W  (ADDR_W),
        .REG_ADDR(REG_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .set_flag  (set_flag),
        .ctl       (ctl),
        .rdata     (bus_rdata),
        .wr_hit    (wr_hit),
        .misuse_err(misuse_err)
    );

    always_comb begin
        ctl_en   = ctl.en;
        ctl_flag = ctl.flag;
    end

    cmp_evt_detect u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctl_en),
        .mode    (ctl.mode),
        .raw     (cmp_raw),
        .tick    (sample_tick),
        .gated   (cmp_gated),
        .rise    (en_rise),
        .acc     (db_acc),
        .set_flag(set_flag)
    );

    always_comb begin
        chan_sel       = ctl.chan;
        inputs_connect = ctl.conn;
        irq            = ctl_flag & irq_en;
    end

endmodule

// File: rtl/cmp_evt_chk.sv
module cmp_evt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       flag,
    input logic       gated,
    input logic       wr_hit,
    input logic       wr_flag,
    input logic       conn,
    input logic [1:0] chan,
    input logic       err,
    input logic       tick,
    input logic       rise,
    input logic       acc
);

    a_r3_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !gated);

    a_r4_no_set_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !flag) |=> !flag);

    a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_hit && !wr_flag)) |=> flag);

    a_r8_db_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick && !rise) |=> $stable(acc));

    a_r9_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !wr_hit) |=> (flag == $past(flag)));

    a_r10_chan_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (conn && wr_hit) |=> $stable(chan));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

endmodule

bind cmp_evt_ctrl cmp_evt_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (ctl_en),
    .flag   (ctl_flag),
    .gated  (cmp_gated),
    .wr_hit (wr_hit),
    .wr_flag(bus_wdata[4]),
    .conn   (inputs_connect),
    .chan   (chan_sel),
    .err    (misuse_err),
    .tick   (sample_tick),
    .rise   (en_rise),
    .acc    (db_acc)
);

// File: tb/cmp_evt_ctrl_bench.sv
module cmp_evt_ctrl_bench;

    localparam logic [7:0] REG = 8'h24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = REG;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cmp_raw = 1'b0;
    logic       sample_tick = 1'b0;
    logic       irq_en = 1'b0;
    logic [1:0] chan_sel;
    logic       inputs_connect;
    logic       cmp_gated;
    logic       irq;
    logic       misuse_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    cmp_evt_ctrl u_cmp_evt_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .cmp_raw       (cmp_raw),
        .sample_tick   (sample_tick),
        .irq_en        (irq_en),
        .chan_sel      (chan_sel),
        .inputs_connect(inputs_connect),
        .cmp_gated     (cmp_gated),
        .irq           (irq),
        .misuse_err    (misuse_err)
    );

    function automatic logic [7:0] pick(int sel);
        case (sel)
            0: return bus_rdata;
            1: return {7'd0, bus_rdata[4]};
            2: return {7'd0, irq};
            3: return {7'd0, cmp_gated};
            4: return {7'd0, misuse_err};
            5: return {6'd0, chan_sel};
            default: return {7'd0, inputs_connect};
        endcase
    endfunction

    initial begin
        forever begin
            sb_item_t it;
            logic [7:0] act;
            wait (sb_q.size() != 0);
            it  = sb_q.pop_front();
            act = pick(it.sel);
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic chk(string req, int sel, logic [7:0] exp);
        sb_item_t it;
        #1;
        it.req = req;
        it.sel = sel;
        it.exp = exp;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic arm(logic [2:0] m);
        wr({5'b11000, m});
        wr({5'b11001, m});
        step(1);
    endtask

    task automatic tick();
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 reset value", 0, 8'hC0);
        chk("R1 reset channel", 5, 8'd3);
        chk("R1 reset connect", 6, 8'd0);
        chk("R1 reset gated", 3, 8'd0);
        chk("R1 reset irq", 2, 8'd0);
        chk("R1 reset error", 4, 8'd0);
        bus_addr = 8'h25;
        chk("R2 other address reads zero", 0, 8'h00);
        bus_addr = REG;

        wr(8'hC1);
        cmp_raw = 1'b1;
        chk("R3 gated forced low when disabled", 3, 8'd0);
        step(2);
        chk("R4 no set while disabled", 1, 8'd0);
        cmp_raw = 1'b0;

        arm(3'b001);
        cmp_raw = 1'b1;
        chk("R3 gated follows raw when enabled", 3, 8'd1);
        step(1);
        chk("R7 rising edge sets flag", 1, 8'd1);
        irq_en = 1'b0;
        chk("R12 irq masked", 2, 8'd0);
        irq_en = 1'b1;
        chk("R12 irq asserted", 2, 8'd1);
        cmp_raw = 1'b0;
        step(2);
        chk("R5 flag sticky", 1, 8'd1);
        wr(8'hC9);
        chk("R5 write zero clears", 1, 8'd0);
        wr(8'hD9);
        chk("R5 write one does not set", 1, 8'd0);
        chk("R12 irq low with flag clear", 2, 8'd0);

        wr(8'hC1);
        cmp_raw = 1'b1;
        step(1);
        wr(8'hC9);
        step(3);
        chk("R9 no spurious edge on enable", 1, 8'd0);
        cmp_raw = 1'b0;

        cmp_raw = 1'b1;
        arm(3'b100);
        chk("R7 falling mode idle while high", 1, 8'd0);
        cmp_raw = 1'b0;
        step(1);
        chk("R7 falling edge sets flag", 1, 8'd1);

        arm(3'b101);
        cmp_raw = 1'b1;
        step(1);
        chk("R7 toggle on rise", 1, 8'd1);
        wr(8'hCD);
        chk("R7 toggle cleared", 1, 8'd0);
        cmp_raw = 1'b0;
        step(1);
        chk("R7 toggle on fall", 1, 8'd1);

        arm(3'b111);
        step(2);
        chk("R6 high level idle while low", 1, 8'd0);
        cmp_raw = 1'b1;
        step(1);
        chk("R6 high level sets", 1, 8'd1);
        wr(8'hCF);
        chk("R6 clear overridden by level", 1, 8'd1);

        arm(3'b000);
        step(2);
        chk("R6 low level idle while high", 1, 8'd0);
        cmp_raw = 1'b0;
        step(1);
        chk("R6 low level sets", 1, 8'd1);

        arm(3'b011);
        cmp_raw = 1'b1;
        step(4);
        chk("R8 no acceptance without ticks", 1, 8'd0);
        tick();
        step(1);
        chk("R8 one tick not enough", 1, 8'd0);
        tick();
        step(1);
        chk("R8 two ticks accept rising", 1, 8'd1);
        wr(8'hCB);
        cmp_raw = 1'b0;
        tick();
        cmp_raw = 1'b1;
        tick();
        step(2);
        chk("R8 one-tick glitch ignored", 1, 8'd0);

        arm(3'b110);
        cmp_raw = 1'b0;
        tick();
        step(1);
        chk("R8 debounced fall pending", 1, 8'd0);
        tick();
        step(1);
        chk("R8 debounced fall accepted", 1, 8'd1);

        arm(3'b010);
        cmp_raw = 1'b1;
        tick();
        tick();
        step(1);
        chk("R8 debounced toggle accepted", 1, 8'd1);
        cmp_raw = 1'b0;

        wr(8'h40);
        chk("R10 channel written while detached", 5, 8'd1);
        wr(8'h60);
        chk("R11 connect output high", 6, 8'd1);
        wr(8'hA0);
        chk("R10 channel kept while connected", 0, 8'h60);
        chk("R10 misuse error raised", 4, 8'd1);
        wr(8'h80);
        chk("R10 channel kept when clearing connect", 0, 8'h40);
        chk("R10 error stays set", 4, 8'd1);
        wr(8'h80);
        chk("R10 channel changes once detached", 5, 8'd2);
        chk("R11 connect output low", 6, 8'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule